// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block records the value of a free-running counter at the moment a chosen edge appears on an asynchronous input pin. The pin first passes through a two-stage synchroniser. A glitch filter then accepts a new level only after a run of consecutive samples agrees with it. An edge detector with selectable polarity follows, and then an event divider that lets only every 1st, 2nd, 4th or 8th qualifying edge through.

Each capture that passes the divider copies the counter into the capture register and raises a capture flag. A capture that lands while the flag is still up also raises an over-capture flag. Software can force a capture with a one-cycle strobe. It clears the capture flag by reading the capture register or by a clear write. The over-capture flag has its own clear.

Top module: `icap_channel`

## Requirements
- R1: With filter code 0000 the filter is bypassed: a rising level on the pin that is present before clock edge k is captured at edge k+3, so the capture flag is 0 after edge k+2 and 1 after edge k+3.
- R2: Filter codes 0001, 0010 and 0011 sample at the undivided core clock and need 2, 4 and 8 consecutive samples at the new level. With code 0011, a 7-cycle pulse produces no capture and an 8-cycle pulse produces one.
- R3: Filter codes 0100 to 1111 sample every D×E core cycles. D is set by the sampling-division field: 00 gives 1, 01 gives 2, 10 gives 4, and the reserved code 11 behaves as 00. Code 0100 uses E=2 with 6 samples. With code 0100, a pulse of 8 cycles is rejected at D=1 and a pulse of 16 cycles is accepted. At D=2, a pulse of 16 cycles is rejected and a pulse of 40 cycles is accepted.
- R4: A sample at the old level restarts the filter's run count. With code 0011, the pattern high 5, low 1, high 5, then low produces no capture.
- R5: Edge select 00 captures on rising edges, 01 on falling edges and 11 on both edges. The reserved code 10 captures on no edge.
- R6: The event divider code 00, 01, 10 or 11 gives a capture on every 1st, 2nd, 4th or 8th qualifying edge. The edge count returns to zero whenever capture enable is 0.
- R7: On a capture the counter value is latched and the capture flag is set. If the flag was already 1 at that capture, the over-capture flag is set as well. After reset the capture value and both flags are 0.
- R8: A capture-flag clear or a capture-register read clears the capture flag, except that a capture in the same cycle wins. Only the over-capture clear clears the over-capture flag.
- R9: A one-cycle software capture strobe latches the counter and updates the flags in the same way as a pin edge.
- R10: While capture enable is 0, neither pin edges nor the software strobe cause a capture, and the capture register and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| cnt_i | input | 16 | Free-running counter value |
| pin_i | input | 1 | Asynchronous capture input |
| filt_code_i | input | 4 | Filter code (0000 = bypass) |
| smp_div_i | input | 2 | Sampling-clock division for filter codes 0100 and above |
| edge_sel_i | input | 2 | Edge polarity select |
| evt_div_i | input | 2 | Event divider code |
| cap_en_i | input | 1 | Capture enable |
| sw_cap_i | input | 1 | Software capture strobe |
| rd_cap_i | input | 1 | Capture register read strobe |
| clr_cap_flag_i | input | 1 | Capture flag clear write |
| clr_ovr_flag_i | input | 1 | Over-capture flag clear write |
| cap_val_o | output | 16 | Capture register |
| cap_flag_o | output | 1 | Capture flag |
| ovr_flag_o | output | 1 | Over-capture flag |

## Verification
The properties run on every cycle. They check the latched value against the counter one cycle after each internal capture event and that over-capture sets when the flag is already high. They also check the clear priorities of both flags, that the register holds while capture is disabled, and that the filtered level moves only on a sample tick. Only the bench scenarios can show the pulse-length boundaries of the filter at several sampling rates and the run restart on a disagreeing sample. The same holds for the polarity choices, the divider ratios with their reset on disable, and the exact three-cycle bypass latency from pin to flag.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RSVD = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Consecutive samples needed for each filter code (code 0 = bypass).
  function automatic logic [3:0] flt_len(input logic [3:0] code);
    case (code)
      4'd0:                flt_len = 4'd1;
      4'd1:                flt_len = 4'd2;
      4'd2:                flt_len = 4'd4;
      4'd3:                flt_len = 4'd8;
      4'd4, 4'd6, 4'd8:    flt_len = 4'd6;
      4'd10, 4'd13:        flt_len = 4'd5;
      4'd11, 4'd14:        flt_len = 4'd6;
      default:             flt_len = 4'd8;
    endcase
  endfunction

  // Core cycles between filter samples.
  function automatic logic [7:0] flt_period(input logic [3:0] code, input logic [1:0] sdiv);
    logic [7:0] dts;
    logic [7:0] ext;
    dts = (sdiv == 2'b01) ? 8'd2 : (sdiv == 2'b10) ? 8'd4 : 8'd1;
    if (code < 4'd6)       ext = 8'd2;
    else if (code < 4'd8)  ext = 8'd4;
    else if (code < 4'd10) ext = 8'd8;
    else if (code < 4'd13) ext = 8'd16;
    else                   ext = 8'd32;
    if (code < 4'd4) flt_period = 8'd1;
    else             flt_period = dts * ext;
  endfunction

  function automatic logic [3:0] evt_ratio(input logic [1:0] sel);
    evt_ratio = 4'd1 << sel;
  endfunction

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    case (edge_sel_e'(sel))
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [3:0] code_i,
  input  logic [1:0] sdiv_i,
  output logic       lvl_o,
  output logic       tick_o
);
  import icap_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic [7:0]             tick_cnt;
  logic [7:0]             period;
  logic [3:0]             run_q;
  logic [3:0]             need;

  assign smp    = sync_q[SYNC_STAGES-1];
  assign period = flt_period(code_i, sdiv_i);
  assign need   = flt_len(code_i);
  assign tick_o = (tick_cnt >= period - 8'd1);

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tick_cnt <= '0;
    else if (tick_o) tick_cnt <= '0;
    else             tick_cnt <= tick_cnt + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= 1'b0;
      run_q <= '0;
    end else if (code_i == 4'd0) begin
      lvl_o <= smp;
      run_q <= '0;
    end else if (tick_o) begin
      if (smp == lvl_o) begin
        run_q <= '0;
      end else if (run_q + 4'd1 >= need) begin
        lvl_o <= smp;
        run_q <= '0;
      end else begin
        run_q <= run_q + 4'd1;
      end
    end
  end

endmodule

// File: rtl/icap_edge_div.sv
module icap_edge_div (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [1:0] edge_sel_i,
  input  logic [1:0] evt_div_i,
  input  logic       en_i,
  output logic       edge_o,
  output logic       fire_o
);
  import icap_pkg::*;

  logic       lvl_d;
  logic [2:0] evt_cnt;
  logic       last_of_group;

  assign edge_o        = edge_hit(edge_sel_i, lvl_i & ~lvl_d, ~lvl_i & lvl_d);
  assign last_of_group = ({1'b0, evt_cnt} >= evt_ratio(evt_div_i) - 4'd1);
  assign fire_o        = en_i & edge_o & last_of_group;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              evt_cnt <= '0;
    else if (!en_i)          evt_cnt <= '0;
    else if (edge_o) begin
      if (last_of_group)     evt_cnt <= '0;
      else                   evt_cnt <= evt_cnt + 3'd1;
    end
  end

endmodule

// File: rtl/icap_store.sv
module icap_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_evt_i,
  input  logic             rd_i,
  input  logic             clr_flag_i,
  input  logic             clr_ovr_i,
  output logic [CNT_W-1:0] val_o,
  output logic             flag_o,
  output logic             ovr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         val_o <= '0;
    else if (cap_evt_i) val_o <= cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_o <= 1'b0;
    else if (cap_evt_i)          flag_o <= 1'b1;
    else if (rd_i || clr_flag_i) flag_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ovr_o <= 1'b0;
    else if (cap_evt_i && flag_o) ovr_o <= 1'b1;
    else if (clr_ovr_i)           ovr_o <= 1'b0;
  end

endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic [3:0]       filt_code_i,
  input  logic [1:0]       smp_div_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [1:0]       evt_div_i,
  input  logic             cap_en_i,
  input  logic             sw_cap_i,
  input  logic             rd_cap_i,
  input  logic             clr_cap_flag_i,
  input  logic             clr_ovr_flag_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             ovr_flag_o
);

  logic filt_lvl;
  logic smp_tick;
  logic filt_edge;
  logic evt_fire;
  logic cap_evt;

  icap_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .code_i (filt_code_i),
    .sdiv_i (smp_div_i),
    .lvl_o  (filt_lvl),
    .tick_o (smp_tick)
  );

  icap_edge_div u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (filt_lvl),
    .edge_sel_i (edge_sel_i),
    .evt_div_i  (evt_div_i),
    .en_i       (cap_en_i),
    .edge_o     (filt_edge),
    .fire_o     (evt_fire)
  );

  assign cap_evt = evt_fire | (sw_cap_i & cap_en_i);

  icap_store #(.CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_i),
    .cap_evt_i  (cap_evt),
    .rd_i       (rd_cap_i),
    .clr_flag_i (clr_cap_flag_i),
    .clr_ovr_i  (clr_ovr_flag_i),
    .val_o      (cap_val_o),
    .flag_o     (cap_flag_o),
    .ovr_o      (ovr_flag_o)
  );

endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic [3:0]       filt_code_i,
  input logic             cap_en_i,
  input logic             rd_cap_i,
  input logic             clr_cap_flag_i,
  input logic             clr_ovr_flag_i,
  input logic             cap_evt,
  input logic             evt_fire,
  input logic             filt_edge,
  input logic             smp_tick,
  input logic             filt_lvl,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             ovr_flag_o
);

  // R7
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val_o == $past(cnt_i)) && cap_flag_o);

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cap_flag_o) |=> ovr_flag_o);

  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag_o && !clr_ovr_flag_i) |=> ovr_flag_o);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_cap_i || clr_cap_flag_i) && !cap_evt) |=> !cap_flag_o);

  // R10
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_i |=> $stable(cap_val_o));

  // R10
  dis_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en_i && !cap_flag_o) |=> !cap_flag_o);

  // R6
  fire_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |-> (filt_edge && cap_en_i));

  // R2
  filt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_code_i != 4'd0 && !smp_tick) |=> $stable(filt_lvl));

endmodule

bind icap_channel icap_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cnt_i          (cnt_i),
  .filt_code_i    (filt_code_i),
  .cap_en_i       (cap_en_i),
  .rd_cap_i       (rd_cap_i),
  .clr_cap_flag_i (clr_cap_flag_i),
  .clr_ovr_flag_i (clr_ovr_flag_i),
  .cap_evt        (cap_evt),
  .evt_fire       (evt_fire),
  .filt_edge      (filt_edge),
  .smp_tick       (smp_tick),
  .filt_lvl       (filt_lvl),
  .cap_val_o      (cap_val_o),
  .cap_flag_o     (cap_flag_o),
  .ovr_flag_o     (ovr_flag_o)
);

// File: tb/icap_channel_test.sv
module icap_channel_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = 16'h0;
  logic        pin_i = 1'b0;
  logic [3:0]  filt_code_i = 4'd0;
  logic [1:0]  smp_div_i = 2'b00;
  logic [1:0]  edge_sel_i = 2'b00;
  logic [1:0]  evt_div_i = 2'b00;
  logic        cap_en_i = 1'b0;
  logic        sw_cap_i = 1'b0;
  logic        rd_cap_i = 1'b0;
  logic        clr_cap_flag_i = 1'b0;
  logic        clr_ovr_flag_i = 1'b0;
  logic [15:0] cap_val_o;
  logic        cap_flag_o;
  logic        ovr_flag_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        flag_prev = 1'b0;
  bit          done = 1'b0;

  icap_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .pin_i(pin_i),
    .filt_code_i(filt_code_i), .smp_div_i(smp_div_i), .edge_sel_i(edge_sel_i),
    .evt_div_i(evt_div_i), .cap_en_i(cap_en_i), .sw_cap_i(sw_cap_i),
    .rd_cap_i(rd_cap_i), .clr_cap_flag_i(clr_cap_flag_i),
    .clr_ovr_flag_i(clr_ovr_flag_i), .cap_val_o(cap_val_o),
    .cap_flag_o(cap_flag_o), .ovr_flag_o(ovr_flag_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: one expected capture value.
  task automatic expect_cap(input logic [15:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // Monitor: every rise of the capture flag consumes one expected item.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cap_flag_o && !flag_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected capture", {16'h0, cap_val_o}, 32'h0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cap_val_o == e, t, {16'h0, cap_val_o}, {16'h0, e});
        end
      end
      flag_prev = cap_flag_o;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pin_i = 1'b1;
    cycles(hi);
    pin_i = 1'b0;
    cycles(lo);
  endtask

  task automatic rd_pulse();
    rd_cap_i = 1'b1;
    cycles(1);
    rd_cap_i = 1'b0;
  endtask

  // Wait for the pipeline, confirm nothing is still outstanding, clear the flag.
  task automatic drain(input string req, input int wait_n);
    cycles(wait_n);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
    rd_pulse();
    check(cap_flag_o == 1'b0, req, cap_flag_o, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(4);
    // R7 reset state
    check(cap_val_o == 16'h0, "R7 reset value", cap_val_o, 0);
    check(cap_flag_o == 1'b0, "R7 reset flag", cap_flag_o, 0);
    check(ovr_flag_o == 1'b0, "R7 reset ovr", ovr_flag_o, 0);
    rst_n = 1'b1;
    cap_en_i = 1'b1;
    cycles(4);

    // R1 bypass latency
    filt_code_i = 4'd0;
    cnt_i = 16'h1234;
    expect_cap(16'h1234, "R1 bypass capture value");
    pin_i = 1'b1;
    cycles(3);
    check(cap_flag_o == 1'b0, "R1 flag after k+2", cap_flag_o, 0);
    cycles(1);
    check(cap_flag_o == 1'b1, "R1 flag after k+3", cap_flag_o, 1);
    pin_i = 1'b0;
    drain("R1 drain", 10);

    // R2 eight-sample filter at core rate
    filt_code_i = 4'd3;
    cycles(20);
    cnt_i = 16'h2001;
    pulse(7, 30);
    drain("R2 7-cycle pulse rejected", 10);
    cnt_i = 16'h2002;
    expect_cap(16'h2002, "R2 8-cycle pulse accepted");
    pulse(8, 30);
    drain("R2 8-cycle drain", 10);

    // R4 restart on disagreeing sample
    cnt_i = 16'h4004;
    pulse(5, 1);
    pulse(5, 30);
    drain("R4 broken run rejected", 10);

    // R3 divided sampling: code 0100 (E=2, 6 samples)
    filt_code_i = 4'd4;
    smp_div_i = 2'b00;
    cycles(40);
    cnt_i = 16'h3001;
    pulse(8, 60);
    drain("R3 D=1 8-cycle rejected", 10);
    cnt_i = 16'h3002;
    expect_cap(16'h3002, "R3 D=1 16-cycle accepted");
    pulse(16, 60);
    drain("R3 D=1 drain", 10);
    smp_div_i = 2'b01;
    cnt_i = 16'h3003;
    pulse(16, 80);
    drain("R3 D=2 16-cycle rejected", 10);
    cnt_i = 16'h3004;
    expect_cap(16'h3004, "R3 D=2 40-cycle accepted");
    pulse(40, 80);
    drain("R3 D=2 drain", 10);
    smp_div_i = 2'b11;
    cnt_i = 16'h3005;
    pulse(8, 60);
    drain("R3 reserved D 8-cycle rejected", 10);
    cnt_i = 16'h3006;
    expect_cap(16'h3006, "R3 reserved D 16-cycle accepted");
    pulse(16, 60);
    drain("R3 reserved D drain", 10);
    smp_div_i = 2'b00;

    // R5 edge polarity
    filt_code_i = 4'd0;
    cycles(4);
    edge_sel_i = 2'b01;
    cnt_i = 16'h5001;
    pin_i = 1'b1;
    cycles(10);
    check(cap_flag_o == 1'b0, "R5 falling select ignores rise", cap_flag_o, 0);
    expect_cap(16'h5002, "R5 falling edge capture");
    cnt_i = 16'h5002;
    pin_i = 1'b0;
    drain("R5 falling drain", 10);
    edge_sel_i = 2'b11;
    cnt_i = 16'h5003;
    expect_cap(16'h5003, "R5 both: rising");
    expect_cap(16'h5004, "R5 both: falling");
    pin_i = 1'b1;
    cycles(6);
    rd_pulse();
    cnt_i = 16'h5004;
    pin_i = 1'b0;
    drain("R5 both drain", 10);
    edge_sel_i = 2'b10;
    pulse(5, 10);
    drain("R5 reserved select no capture", 10);
    edge_sel_i = 2'b00;

    // R6 event divider
    evt_div_i = 2'b01;
    expect_cap(16'h6002, "R6 every 2nd edge (first group)");
    cnt_i = 16'h6001; pulse(3, 3);
    cnt_i = 16'h6002; pulse(3, 3);
    drain("R6 div2 group 1", 6);
    expect_cap(16'h6004, "R6 every 2nd edge (second group)");
    cnt_i = 16'h6003; pulse(3, 3);
    cnt_i = 16'h6004; pulse(3, 3);
    drain("R6 div2 group 2", 6);
    evt_div_i = 2'b11;
    expect_cap(16'h6108, "R6 every 8th edge");
    for (int i = 1; i <= 8; i++) begin
      cnt_i = 16'h6100 + 16'(i);
      pulse(3, 3);
    end
    drain("R6 div8", 6);
    evt_div_i = 2'b01;
    cnt_i = 16'h6201; pulse(3, 3);
    cap_en_i = 1'b0; cycles(2); cap_en_i = 1'b1;
    cnt_i = 16'h6202; pulse(3, 3);
    expect_cap(16'h6203, "R6 count reset by disable");
    cnt_i = 16'h6203; pulse(3, 3);
    drain("R6 disable reset", 6);
    evt_div_i = 2'b00;

    // R10 disabled channel
    cap_en_i = 1'b0;
    cnt_i = 16'hA001;
    pulse(3, 6);
    sw_cap_i = 1'b1; cycles(1); sw_cap_i = 1'b0;
    cycles(3);
    check(cap_val_o == 16'h6203, "R10 value held while disabled", cap_val_o, 16'h6203);
    check(cap_flag_o == 1'b0, "R10 no flag while disabled", cap_flag_o, 0);
    cap_en_i = 1'b1;
    cycles(2);

    // R9 software strobe
    cnt_i = 16'h9001;
    expect_cap(16'h9001, "R9 software capture");
    sw_cap_i = 1'b1; cycles(1); sw_cap_i = 1'b0;
    cycles(1);
    check(cap_flag_o == 1'b1, "R9 flag set by strobe", cap_flag_o, 1);
    check(ovr_flag_o == 1'b0, "R9 no ovr on first", ovr_flag_o, 0);

    // R7 over-capture
    cnt_i = 16'h7002;
    sw_cap_i = 1'b1; cycles(1); sw_cap_i = 1'b0;
    check(cap_val_o == 16'h7002, "R7 second capture value", cap_val_o, 16'h7002);
    check(ovr_flag_o == 1'b1, "R7 ovr set", ovr_flag_o, 1);

    // R8 clearing rules
    clr_cap_flag_i = 1'b1; cycles(1); clr_cap_flag_i = 1'b0;
    check(cap_flag_o == 1'b0, "R8 flag clear write", cap_flag_o, 0);
    check(ovr_flag_o == 1'b1, "R8 ovr kept by flag clear", ovr_flag_o, 1);
    rd_pulse();
    check(ovr_flag_o == 1'b1, "R8 ovr kept by read", ovr_flag_o, 1);
    clr_ovr_flag_i = 1'b1; cycles(1); clr_ovr_flag_i = 1'b0;
    check(ovr_flag_o == 1'b0, "R8 ovr clear write", ovr_flag_o, 0);
    cnt_i = 16'h8003;
    expect_cap(16'h8003, "R8 capture beats clear");
    sw_cap_i = 1'b1; clr_cap_flag_i = 1'b1; rd_cap_i = 1'b1;
    cycles(1);
    sw_cap_i = 1'b0; clr_cap_flag_i = 1'b0; rd_cap_i = 1'b0;
    check(cap_flag_o == 1'b1, "R8 capture wins over clear", cap_flag_o, 1);
    check(ovr_flag_o == 1'b0, "R8 no ovr from clean flag", ovr_flag_o, 0);
    drain("R8 drain", 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule